// File: doc/BRIEF.md
# Nonvolatile Backup Mode Controller

This block decides when a battery-free nonvolatile memory leaves ordinary SRAM operation to copy its contents into nonvolatile cells (a store) or back from them (a recall). It watches a supply-low comparator flag, the SRAM read and write strobes, a write-in-progress flag and a software store trigger. From these it grants or refuses SRAM accesses and sequences an internal, counter-timed model of the backing array through erase, program and restore phases.

A store on power loss only happens when the memory holds data that is not yet saved. A write counts as done when the write-in-progress flag falls. Before such a store, a fixed drain window lets accesses already in flight finish. During that window reads are still served and new writes are refused. A software store always runs. A recall follows every power-on reset and every supply-low episode. If the supply is low when the recall is asked for, the request waits until the flag clears. While any transfer runs, every SRAM access is blocked and `busy` is high.

Top module: `nvm_backup_ctrl`

## Requirements
- R1: One cycle after `rst_n` rises with `supply_low` low, a recall starts. `nv_restore` and `busy` stay high for RESTORE_CYC cycles, then return low.
- R2: In SRAM mode with `supply_low` low, `rd_grant` equals `rd_req` and `wr_grant` equals `wr_req` in the same cycle.
- R3: `wr_grant` is low in every cycle that `supply_low` is high, including the drain window.
- R4: If `supply_low` rises while no write has completed since the last store or recall, no store starts and `busy` stays low.
- R5: If `supply_low` rises after a write has completed, a drain window of DLY_CYC cycles follows and a store starts after it. During the window `busy` is low and reads are still granted.
- R6: A store drives `nv_erase` for ERASE_CYC cycles and then `nv_prog` for PROG_CYC cycles. `busy` is high for all of them, and at most one of the three phase outputs is high at a time.
- R7: A one-cycle `sw_store` pulse in SRAM mode with `supply_low` low starts a store on the next cycle, even when no write has occurred.
- R8: While `busy` is high, `rd_grant` and `wr_grant` are low regardless of the requests.
- R9: Each supply-low episode latches a recall. The recall starts one cycle after `supply_low` falls and holds `nv_restore` for RESTORE_CYC cycles.
- R10: A write is completed on the cycle `wr_busy` falls. Completing any store or recall marks the memory clean, so a later `supply_low` with no new write starts no store.
- R11: If `supply_low` rises while a store is already running, that store finishes and no second store follows in the same low episode.
- R12: While `rst_n` is low, `busy`, `nv_erase`, `nv_prog` and `nv_restore` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| supply_low | input | 1 | Supply comparator flag, high when the supply is below threshold |
| rd_req | input | 1 | SRAM read strobe |
| wr_req | input | 1 | SRAM write strobe (new write request) |
| wr_busy | input | 1 | Write in progress; its falling edge marks a completed write |
| sw_store | input | 1 | Software store trigger pulse |
| rd_grant | output | 1 | Read allowed; also enables the SRAM outputs |
| wr_grant | output | 1 | Write allowed |
| busy | output | 1 | A nonvolatile transfer is running |
| nv_erase | output | 1 | Backing array in erase phase |
| nv_prog | output | 1 | Backing array in program phase |
| nv_restore | output | 1 | Backing array restoring SRAM contents |

## Verification
The hardest case to reach is a supply drop that lands on a store the software has already started. The bench first completes a write so the memory is dirty, then pulses `sw_store`. It raises `supply_low` on the first erase cycle. It then checks that the phase lengths match a single store, and that `busy` stays low over a long stretch of the low episode. A second hard case is the clean-after-store rule. It needs a write, a software store and then a supply drop, in that order, and the check is that the drop leaves `busy` low.

// File: rtl/nvm_backup_ctrl.sv
module nvm_backup_ctrl #(
  parameter int DLY_CYC     = 4,
  parameter int ERASE_CYC   = 3,
  parameter int PROG_CYC    = 5,
  parameter int RESTORE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic rd_req,
  input  logic wr_req,
  input  logic wr_busy,
  input  logic sw_store,
  output logic rd_grant,
  output logic wr_grant,
  output logic busy,
  output logic nv_erase,
  output logic nv_prog,
  output logic nv_restore
);

  localparam int M1 = (DLY_CYC > ERASE_CYC) ? DLY_CYC : ERASE_CYC;
  localparam int M2 = (PROG_CYC > RESTORE_CYC) ? PROG_CYC : RESTORE_CYC;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX) + 1;

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_ERASE, S_PROG, S_RESTORE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dirty, recall_pend, low_seen, wr_busy_q;
  logic          wr_fin, low_new, cnt_zero, sram_en;

  assign wr_fin   = wr_busy_q & ~wr_busy;
  assign low_new  = supply_low & ~low_seen;
  assign cnt_zero = (cnt == '0);
  assign sram_en  = (st == S_RUN) || (st == S_DRAIN);

  assign rd_grant   = rd_req & sram_en;
  assign wr_grant   = wr_req & sram_en & ~supply_low;
  assign nv_erase   = (st == S_ERASE);
  assign nv_prog    = (st == S_PROG);
  assign nv_restore = (st == S_RESTORE);
  assign busy       = nv_erase | nv_prog | nv_restore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RUN;
      cnt         <= '0;
      dirty       <= 1'b0;
      recall_pend <= 1'b1;
      low_seen    <= 1'b0;
      wr_busy_q   <= 1'b0;
    end else begin
      wr_busy_q <= wr_busy;
      if (wr_fin) dirty <= 1'b1;
      if (!supply_low) begin
        low_seen <= 1'b0;
      end else if (low_new) begin
        low_seen    <= 1'b1;
        recall_pend <= 1'b1;
      end
      if (!cnt_zero) cnt <= cnt - 1'b1;
      case (st)
        S_RUN: begin
          if (recall_pend && !supply_low) begin
            st          <= S_RESTORE;
            cnt         <= CW'(RESTORE_CYC - 1);
            recall_pend <= 1'b0;
          end else if (low_new) begin
            if (dirty || wr_fin) begin
              st  <= S_DRAIN;
              cnt <= CW'(DLY_CYC - 1);
            end
          end else if (sw_store && !supply_low) begin
            st  <= S_ERASE;
            cnt <= CW'(ERASE_CYC - 1);
          end
        end
        S_DRAIN: if (cnt_zero) begin
          st  <= S_ERASE;
          cnt <= CW'(ERASE_CYC - 1);
        end
        S_ERASE: if (cnt_zero) begin
          st  <= S_PROG;
          cnt <= CW'(PROG_CYC - 1);
        end
        S_PROG: if (cnt_zero) begin
          st    <= S_RUN;
          dirty <= 1'b0;
        end
        S_RESTORE: if (cnt_zero) begin
          st    <= S_RUN;
          dirty <= 1'b0;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  p_phase_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_prog, nv_restore}));

  p_erase_then_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_erase) |-> nv_prog);

  p_store_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_erase) |-> $past(st == S_DRAIN || sw_store));

  p_dirty_low_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && low_new && dirty) |=> (st == S_DRAIN));

  p_clean_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && supply_low && !dirty && !wr_fin) |=> !busy);

  p_recall_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_restore) |-> $past(recall_pend && !supply_low));

  p_clean_after_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_prog) |-> !dirty);

endmodule

// File: tb/test_nvm_backup_ctrl.sv
module test_nvm_backup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4, ERS = 3, PRG = 5, RST = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_low = 1'b0, rd_req = 1'b0, wr_req = 1'b0, wr_busy = 1'b0, sw_store = 1'b0;
  logic rd_grant, wr_grant, busy, nv_erase, nv_prog, nv_restore;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_backup_ctrl #(.DLY_CYC(DLY), .ERASE_CYC(ERS), .PROG_CYC(PRG), .RESTORE_CYC(RST)) i_nvm_backup_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .rd_req(rd_req), .wr_req(wr_req),
    .wr_busy(wr_busy), .sw_store(sw_store), .rd_grant(rd_grant), .wr_grant(wr_grant),
    .busy(busy), .nv_erase(nv_erase), .nv_prog(nv_prog), .nv_restore(nv_restore));

  // {supply_low, rd_req, wr_req, exp_rd_grant, exp_wr_grant}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00000, 5'b01010, 5'b00101, 5'b01111,
    5'b10000, 5'b11010, 5'b10100, 5'b11110};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int pre, ne, np, nr, nb, prd, pwr, gb;

  task automatic measure();
    pre = 0; ne = 0; np = 0; nr = 0; nb = 0; prd = 0; pwr = 0; gb = 0;
    for (int i = 0; i < 40 && !busy; i++) begin
      pre++;
      if (rd_grant) prd++;
      if (wr_grant) pwr++;
      @(negedge clk);
    end
    for (int i = 0; i < 40 && busy; i++) begin
      nb++;
      if (nv_erase) ne++;
      if (nv_prog) np++;
      if (nv_restore) nr++;
      if (rd_grant || wr_grant) gb++;
      if (nv_prog && ne != ERS) ne = -100;
      @(negedge clk);
    end
  endtask

  task automatic watch(input int n, output int b);
    b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) b++;
    end
  endtask

  task automatic do_write();
    wr_req = 1'b1; wr_busy = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; wr_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_pulse();
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
  endtask

  task automatic supply_return();
    supply_low = 1'b0;
    @(negedge clk);
    measure();
    chk("R9 recall waits for supply, pre", pre, 0);
    chk("R9 restore length", nr, RST);
    chk("R8 no grants during restore", gb, 0);
  endtask

  initial begin
    int b;
    rd_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 busy in reset", busy, 0);
    chk("R12 phases in reset", {nv_erase, nv_prog, nv_restore}, 0);

    rst_n = 1'b1; wr_req = 1'b1;
    @(negedge clk);
    measure();
    chk("R1 recall right after reset", pre, 0);
    chk("R1 restore length", nr, RST);
    chk("R1 busy length", nb, RST);
    chk("R8 grants blocked in restore", gb, 0);
    rd_req = 1'b0; wr_req = 1'b0;

    for (int i = 0; i < 8; i++) begin
      {supply_low, rd_req, wr_req} = VEC[i][4:2];
      #1;
      chk(VEC[i][4] ? "R3 write inhibit table rd" : "R2 gating table rd", rd_grant, VEC[i][1]);
      chk(VEC[i][4] ? "R3 write inhibit table wr" : "R2 gating table wr", wr_grant, VEC[i][0]);
      @(negedge clk);
    end
    rd_req = 1'b0; wr_req = 1'b0;
    watch(12, b);
    chk("R4 clean supply drop starts no store", b, 0);
    supply_return();

    do_write();
    supply_low = 1'b1; rd_req = 1'b1; wr_req = 1'b1;
    @(negedge clk);
    measure();
    chk("R5 drain window length", pre, DLY);
    chk("R5 reads served in drain", prd, DLY);
    chk("R3 writes refused in drain", pwr, 0);
    chk("R6 erase length", ne, ERS);
    chk("R6 program length", np, PRG);
    chk("R6 store busy length", nb, ERS + PRG);
    chk("R8 no grants during store", gb, 0);
    watch(10, b);
    chk("R11 one store per low episode", b, 0);
    rd_req = 1'b0; wr_req = 1'b0;
    supply_return();

    sw_pulse();
    measure();
    chk("R7 sw store on clean memory, pre", pre, 0);
    chk("R7 sw store erase", ne, ERS);
    chk("R7 sw store program", np, PRG);

    do_write();
    sw_pulse();
    supply_low = 1'b1;
    measure();
    chk("R11 running store, total busy", nb, ERS + PRG);
    chk("R11 running store, erase", ne, ERS);
    watch(15, b);
    chk("R11 no second store", b, 0);
    supply_return();

    do_write();
    sw_pulse();
    measure();
    chk("R10 store after write", nb, ERS + PRG);
    supply_low = 1'b1;
    watch(15, b);
    chk("R10 memory clean after store", b, 0);
    supply_return();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule